// File: doc/BRIEF.md
# Pattern-Based Pixel Culling Unit

The unit sits in a camera pixel stream. It thins the stream with repeating 8-bit patterns: one horizontal pattern for even lines, one for odd lines, and one vertical pattern that picks whole lines. It also caps how many lines reach memory in each frame. Software programs a cull word and a line-budget word through a small write port. The unit keeps those values in shadow registers and copies them into the working set only when the vertical sync pulse arrives, so a frame never sees a half-updated configuration.

The input stream is a pixel bus with a valid strobe plus one-cycle horizontal and vertical sync pulses. A vertical sync pulse opens a frame. Each horizontal sync pulse opens a line, and the first one after a vertical sync opens line 0. The output is the same pixel bus, delayed by one register, with a valid strobe that rises only for pixels that pass all three patterns and fall inside the line budget.

Top module: `pixel_cull_unit`

## Requirements
- R1: After reset, both readbacks show the defaults: every pattern is 0xFF and the budget field is 0. The output valid is low. With the defaults, only line 0 of a frame is forwarded, and all of its pixels pass.
- R2: Within a line, valid pixels are numbered k = 0, 1, 2, ... from the opening horizontal sync. Pixel k passes the horizontal test when bit (k mod 8) of the line's horizontal pattern is 1; a 0 bit culls it. Even lines use the pattern in cull-word bits 31:24.
- R3: Line parity starts even for line 0 of a frame and alternates on every line, culled or not. Odd lines use the horizontal pattern in cull-word bits 23:16.
- R4: Line j of a frame is kept only when bit (j mod 8) of the vertical pattern, cull-word bits 7:0, is 1.
- R5: Let N be the value of the 15-bit budget field. Only the first N+1 lines of a frame that pass the vertical pattern are forwarded. Every later line in that frame is suppressed completely, until the next vertical sync.
- R6: Writes change only the shadow copies. The patterns and the budget that govern a frame are the shadow values as they stood in the cycle the frame's vertical sync was high.
- R7: A write with select 0 loads the cull word, and a write with select 1 loads the budget word from bits 14:0. A read with select 0 returns the cull word with bits 15:8 at zero. A read with select 1 returns the budget in bits 14:0 with all other bits at zero.
- R8: A forwarded pixel appears on the output one clock after it is presented at the input, with its data unchanged.
- R9: Pixels presented in a sync cycle are never forwarded. Pixels presented after a vertical sync but before that frame's first horizontal sync are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 cull word, 1 budget word |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 cull word, 1 budget word |
| rdData | output | 32 | Read data (shadow values, combinational) |
| pixIn | input | DATA_W | Input pixel data |
| pixValidIn | input | 1 | Input pixel valid |
| hsync | input | 1 | One-cycle line start pulse |
| vsync | input | 1 | One-cycle frame start pulse |
| pixOut | output | DATA_W | Output pixel data |
| pixValidOut | output | 1 | Output valid for retained pixels |

## Verification
The assertions assume that horizontal and vertical sync arrive as separate pulses, never both high in the same cycle. They also assume that the budget word is at most 32767, so the per-frame line counter cannot pass N+1. The bench keeps to both assumptions by building every frame from dedicated vertical-sync and horizontal-sync cycles. It does drive valid pixels inside those sync cycles, to show that such pixels are dropped. Writes are issued only in cycles with neither sync high.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int WORD_W   = 32;
  localparam int PAT_W    = 8;
  localparam int IDX_W    = $clog2(PAT_W);
  localparam int EVEN_LSB = 24;
  localparam int ODD_LSB  = 16;
  localparam int VERT_LSB = 0;

  // control-to-datapath strobes
  typedef struct packed {
    logic take;   // a pixel inside a frame, outside sync cycles
    logic fire;   // that pixel survives all culling
  } pcuStrobe_t;
endpackage

// File: rtl/pcu_regs.sv
module pcu_regs
  import pcu_pkg::*;
#(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdSel,
  output logic [WORD_W-1:0] rdData,
  output logic [PAT_W-1:0]  shEven,
  output logic [PAT_W-1:0]  shOdd,
  output logic [PAT_W-1:0]  shVert,
  output logic [LINE_W-1:0] shNlv
);
  localparam int RSV_W = ODD_LSB - (VERT_LSB + PAT_W);
  localparam int PAD_W = WORD_W - LINE_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shEven <= '1;
      shOdd  <= '1;
      shVert <= '1;
      shNlv  <= '0;
    end else if (wrEn) begin
      if (!wrSel) begin
        shEven <= wrData[EVEN_LSB +: PAT_W];
        shOdd  <= wrData[ODD_LSB  +: PAT_W];
        shVert <= wrData[VERT_LSB +: PAT_W];
      end else begin
        shNlv  <= wrData[LINE_W-1:0];
      end
    end
  end

  always_comb begin
    if (rdSel) rdData = {{PAD_W{1'b0}}, shNlv};
    else       rdData = {shEven, shOdd, {RSV_W{1'b0}}, shVert};
  end

  // R7
  nlv_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> (shNlv == $past(wrData[LINE_W-1:0])));

  // R7
  cull_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (shVert == $past(wrData[VERT_LSB +: PAT_W])));
endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              pixValidIn,
  input  logic [PAT_W-1:0]  shEven,
  input  logic [PAT_W-1:0]  shOdd,
  input  logic [PAT_W-1:0]  shVert,
  input  logic [LINE_W-1:0] shNlv,
  output pcuStrobe_t        strb
);
  localparam int CNT_W = LINE_W + 1;

  logic [PAT_W-1:0]  actEven, actOdd, actVert;
  logic [LINE_W-1:0] actNlv;
  logic              inFrame;
  logic [IDX_W-1:0]  pixIdx;
  logic [IDX_W-1:0]  lineIdx;
  logic              parity;
  logic              lineOn;
  logic [CNT_W-1:0]  fwdCnt;

  // next-line decisions taken at a horizontal sync
  logic [IDX_W-1:0]  nextIdx;
  logic              nextPar;
  logic [CNT_W-1:0]  baseCnt;
  logic              nextOn;
  logic              lineStart;

  assign lineStart = hsync && !vsync;

  always_comb begin
    if (inFrame) begin
      nextIdx = lineIdx + 1'b1;
      nextPar = ~parity;
      baseCnt = fwdCnt;
    end else begin
      nextIdx = '0;
      nextPar = 1'b0;
      baseCnt = '0;
    end
    nextOn = actVert[nextIdx] && (baseCnt <= {1'b0, actNlv});
  end

  // shadow-to-active transfer on vertical sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actEven <= '1;
      actOdd  <= '1;
      actVert <= '1;
      actNlv  <= '0;
    end else if (vsync) begin
      actEven <= shEven;
      actOdd  <= shOdd;
      actVert <= shVert;
      actNlv  <= shNlv;
    end
  end

  // line sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      lineIdx <= '0;
      parity  <= 1'b0;
      lineOn  <= 1'b0;
      fwdCnt  <= '0;
    end else if (vsync) begin
      inFrame <= 1'b0;
      lineIdx <= '0;
      parity  <= 1'b0;
      lineOn  <= 1'b0;
      fwdCnt  <= '0;
    end else if (hsync) begin
      inFrame <= 1'b1;
      lineIdx <= nextIdx;
      parity  <= nextPar;
      lineOn  <= nextOn;
      fwdCnt  <= baseCnt + CNT_W'(nextOn);
    end
  end

  logic [PAT_W-1:0] hPat;
  logic             takeNow;

  assign hPat    = parity ? actOdd : actEven;
  assign takeNow = pixValidIn && !hsync && !vsync && inFrame;

  // horizontal pattern index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pixIdx <= '0;
    else if (hsync)     pixIdx <= '0;
    else if (takeNow)   pixIdx <= pixIdx + 1'b1;
  end

  always_comb begin
    strb.take = takeNow;
    strb.fire = takeNow && lineOn && hPat[pixIdx];
  end

  // R5
  fwd_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdCnt <= ({1'b0, actNlv} + 1'b1));

  // R5
  over_budget_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && inFrame && (fwdCnt > {1'b0, actNlv})) |=> !lineOn);

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |=> $stable({actEven, actOdd, actVert, actNlv}));

  // R2
  pix_idx_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (pixIdx == '0));

  // R3
  parity_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !inFrame) |=> (parity == 1'b0));

  // R3
  parity_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && inFrame) |=> (parity != $past(parity)));

  // R4
  fire_needs_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> (lineOn && inFrame));
endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcuStrobe_t        strb,
  input  logic [DATA_W-1:0] pixIn,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValidOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut      <= '0;
      pixValidOut <= 1'b0;
    end else begin
      pixValidOut <= strb.fire;
      if (strb.take) pixOut <= pixIn;
    end
  end

  // R8
  data_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (pixValidOut && (pixOut == $past(pixIn))));
endmodule

// File: rtl/pixel_cull_unit.sv
module pixel_cull_unit
  import pcu_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [31:0]       wrData,
  input  logic              rdSel,
  output logic [31:0]       rdData,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              pixValidIn,
  input  logic              hsync,
  input  logic              vsync,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValidOut
);
  logic [PAT_W-1:0]  shEven, shOdd, shVert;
  logic [LINE_W-1:0] shNlv;
  pcuStrobe_t        strb;

  pcu_regs #(.LINE_W(LINE_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .shEven(shEven), .shOdd(shOdd),
    .shVert(shVert), .shNlv(shNlv)
  );

  pcu_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
    .pixValidIn(pixValidIn), .shEven(shEven), .shOdd(shOdd),
    .shVert(shVert), .shNlv(shNlv), .strb(strb)
  );

  pcu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIn(pixIn),
    .pixOut(pixOut), .pixValidOut(pixValidOut)
  );

  // R9
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsync || vsync) |=> !pixValidOut);

  // R8
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValidOut |-> $past(pixValidIn));
endmodule

// File: tb/pixel_cull_unit_tb.sv
module pixel_cull_unit_tb;
  localparam int DATA_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [DATA_W-1:0] pixIn = '0;
  logic              pixValidIn = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [DATA_W-1:0] pixOut;
  logic              pixValidOut;

  pixel_cull_unit #(.DATA_W(DATA_W), .LINE_W(15)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .pixIn(pixIn), .pixValidIn(pixValidIn),
    .hsync(hsync), .vsync(vsync), .pixOut(pixOut), .pixValidOut(pixValidOut)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // bench model of the specification
  logic [7:0] sEven = 8'hFF, sOdd = 8'hFF, sVert = 8'hFF;
  logic [14:0] sNlv = '0;
  logic [7:0] aEven = 8'hFF, aOdd = 8'hFF, aVert = 8'hFF;
  logic [14:0] aNlv = '0;
  bit   mInFrame = 0;
  int   lineNo = 0, pixK = 0, fwd = 0;
  bit   mLineOn = 0;
  string lineTag = "R4";
  bit   expV = 0;
  logic [DATA_W-1:0] expD = '0;
  string expTag = "R1";

  task automatic checkPrev();
    checks++;
    if (pixValidOut !== expV) begin
      errors++;
      $display("FAIL %s valid: actual=%0b expected=%0b", expTag, pixValidOut, expV);
    end else if (expV && pixOut !== expD) begin
      errors++;
      $display("FAIL R8 data: actual=%h expected=%h", pixOut, expD);
    end
  endtask

  task automatic drive(bit vs, bit hs, bit pv, logic [DATA_W-1:0] d,
                       bit we, bit ws, logic [31:0] wd);
    logic [7:0] hp;
    @(negedge clk);
    checkPrev();
    vsync = vs; hsync = hs; pixValidIn = pv; pixIn = d;
    wrEn = we; wrSel = ws; wrData = wd;
    expV = 0; expTag = "R9";
    if (vs) begin
      aEven = sEven; aOdd = sOdd; aVert = sVert; aNlv = sNlv;
      mInFrame = 0; mLineOn = 0; fwd = 0;
    end else if (hs) begin
      if (!mInFrame) begin mInFrame = 1; lineNo = 0; fwd = 0; end
      else lineNo++;
      pixK = 0;
      if (!aVert[lineNo % 8]) begin mLineOn = 0; lineTag = "R4"; end
      else if (fwd > int'(aNlv)) begin mLineOn = 0; lineTag = "R5"; end
      else begin mLineOn = 1; fwd++; end
    end else if (pv && mInFrame) begin
      hp = (lineNo % 2) ? aOdd : aEven;
      expV = mLineOn && hp[pixK % 8];
      expTag = !mLineOn ? lineTag : ((lineNo % 2) ? "R3" : "R2");
      expD = d;
      pixK++;
    end
    if (we) begin
      if (!ws) begin sEven = wd[31:24]; sOdd = wd[23:16]; sVert = wd[7:0]; end
      else sNlv = wd[14:0];
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    drive(0, 0, 0, '0, 1, sel, d);
  endtask

  task automatic rdCheck(bit sel, logic [31:0] exp, string tag);
    idle();
    rdSel = sel;
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s read sel=%0b: actual=%h expected=%h", tag, sel, rdData, exp);
    end
  endtask

  logic [31:0] midCull = '0;
  logic [31:0] midNlv = '0;

  task automatic frame(int nLines, int nPix, bit midWrite);
    drive(1, 0, 1, 12'hABC, 0, 0, '0);          // R9: pixel in vsync cycle
    drive(0, 0, 1, 12'h111, 0, 0, '0);          // R9: before first hsync
    drive(0, 0, 1, 12'h222, 0, 0, '0);
    for (int l = 0; l < nLines; l++) begin
      drive(0, 1, 1, 12'h333, 0, 0, '0);        // R9: pixel in hsync cycle
      if (midWrite && l == 1) begin
        wr(0, midCull);
        wr(1, midNlv);
      end
      for (int p = 0; p < nPix; p++) begin
        if ((p * 7 + l) % 5 == 3) idle();
        drive(0, 0, 1, DATA_W'($urandom), 0, 0, '0);
      end
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pixValidOut !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid in reset: actual=%0b expected=0", pixValidOut);
    end
    rstN = 1'b1;
    // R1 reset readback
    rdCheck(0, 32'hFFFF_00FF, "R1");
    rdCheck(1, 32'h0000_0000, "R1");
    // R1 defaults: only line 0 forwarded
    frame(4, 10, 0);

    // R2 R3 R4 sweep of pattern sets with a wide budget
    wr(1, 32'd100);
    for (int e = 0; e < 16; e++) begin
      logic [7:0] ev, od, vt;
      ev = 8'(e * 37 + 3);
      od = ~8'(e * 53);
      vt = 8'(e * 29 + 8'h81);
      wr(0, {ev, od, 8'h00, vt});
      frame(10, 17, 0);
    end
    // single-bit horizontal patterns
    for (int b = 0; b < 8; b++) begin
      wr(0, {8'(1 << b), 8'(8'h80 >> b), 8'h00, 8'hFF});
      frame(3, 9, 0);
    end

    // R5 budget sweep
    for (int n = 0; n < 10; n++) begin
      wr(0, 32'hFFFF_00FF);
      wr(1, 32'(n));
      frame(12, 6, 0);
    end
    wr(0, 32'hF0CC_0055);
    wr(1, 32'd2);
    frame(12, 6, 0);

    // R6 mid-frame writes affect only the next frame
    wr(0, 32'hFFFF_00FF);
    wr(1, 32'd20);
    midCull = 32'h0F33_00AA;
    midNlv  = 32'd1;
    frame(8, 10, 1);
    rdCheck(0, 32'h0F33_00AA, "R6");
    frame(8, 10, 0);

    // R7 reserved bits read as zero
    wr(0, 32'h12FF_FF34);
    rdCheck(0, 32'h12FF_0034, "R7");
    wr(1, 32'hFFFF_FFFF);
    rdCheck(1, 32'h0000_7FFF, "R7");
    rdSel = 1'b0;
    frame(4, 8, 0);

    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule